// File: doc/BRIEF.md
# Hardware Loop Branch Unit

This unit carries out the loop-setup instruction and the one-byte loop-back branches of a small processor. A setup instruction is five bytes long: one opcode byte and four bytes after it. It records two values. The loop address register gets the address just past the setup instruction. The loop word register gets the four trailing bytes, packed so that the first fetched byte is the most significant.

Each loop-back branch is a single byte and has no displacement field. When its condition holds on the current Z, N, C and V flags, it sends the program counter to the recorded loop address minus four. When the condition fails, execution falls through to the next byte.

The decode stage presents one instruction per cycle. The next PC and the redirect decision come back in the same cycle. The loop registers take their new values on the clock edge that ends a setup cycle. The loop word is exported so that a fetch stage could issue the first word of the loop body again without a memory access.

Top module: `loop_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `loop_addr` and `loop_word` are zero until the first setup.
- R2: A valid setup (opcode 0xDB) loads `loop_word` with the trailing bytes in big-endian order. `tail_bytes[7:0]` is the first fetched byte and becomes bits 31:24, and `tail_bytes[31:24]` becomes bits 7:0. The new value is visible in the cycle after the setup.
- R3: A valid setup loads `loop_addr` with `instr_addr + 5`, modulo 2^PC_W, visible in the cycle after. In the setup cycle itself the unit drives `claim`=1, `redirect`=0 and `next_pc` = `instr_addr + 5`.
- R4: Opcodes 0xD0 to 0xDA are loop branches. Their low nibble selects the condition:
  - 0: N xor V
  - 1: not (Z or (N xor V))
  - 2: not (N xor V)
  - 3: Z or (N xor V)
  - 4: C
  - 5: not (C or Z)
  - 6: not C
  - 7: C or Z
  - 8: Z
  - 9: not Z
  - A: always
- R5: When a valid loop branch's condition holds, `redirect`=1 and `next_pc` = `loop_addr - 4`, in the same cycle.
- R6: When a valid loop branch's condition fails, `redirect`=0 and `next_pc` = `instr_addr + 1`.
- R7: Opcode 0xDA redirects for every combination of the four flags.
- R8: `loop_addr` and `loop_word` change only on a valid setup. Loop branches, other opcodes and cycles with `instr_valid` low leave them unchanged.
- R9: For any opcode outside 0xD0 to 0xDB, or when `instr_valid` is low, the outputs are `claim`=0, `redirect`=0 and `next_pc` = `instr_addr`.
- R10: A loop branch taken before any setup uses the reset value of `loop_addr`, so `next_pc` = 2^PC_W - 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_addr | input | PC_W | Address of the opcode byte |
| opcode | input | 8 | Opcode byte |
| tail_bytes | input | 32 | The four bytes after the opcode, first fetched byte in bits 7:0 |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| claim | output | 1 | The opcode is a setup or loop branch handled here |
| redirect | output | 1 | A loop branch is taken this cycle |
| next_pc | output | PC_W | Address of the next instruction |
| loop_addr | output | PC_W | Recorded loop address |
| loop_word | output | 32 | Recorded loop word |

## Verification
`claim`, `redirect` and `next_pc` are combinational, so they are due in the same cycle as the instruction. The bench drives each instruction on a falling edge and samples these outputs one time unit later, before the next rising edge. `loop_addr` and `loop_word` are due one rising edge after a setup, so the bench checks them at the following falling edge. The no-change checks on the registers are made the same way, at the falling edge after a non-setup stimulus. The sweeps cover all 176 combinations of loop opcode and flags, plus every opcode the unit does not claim.

// File: rtl/loop_branch_unit.sv
module loop_branch_unit #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [PC_W-1:0] instr_addr,
  input  logic [7:0]      opcode,
  input  logic [31:0]     tail_bytes,
  input  logic            flag_z,
  input  logic            flag_n,
  input  logic            flag_c,
  input  logic            flag_v,
  output logic            claim,
  output logic            redirect,
  output logic [PC_W-1:0] next_pc,
  output logic [PC_W-1:0] loop_addr,
  output logic [31:0]     loop_word
);

  localparam logic [7:0] SETUP_OP    = 8'hDB;
  localparam logic [3:0] LOOP_GROUP  = 4'hD;
  localparam logic [3:0] LAST_COND   = 4'hA;
  localparam int         SETUP_LEN   = 5;
  localparam int         BRANCH_LEN  = 1;
  localparam int         BACK_OFFSET = 4;

  logic is_setup, is_loop, cond_ok, lt;
  logic [31:0] packed_word;

  assign is_setup = instr_valid && (opcode == SETUP_OP);
  assign is_loop  = instr_valid && (opcode[7:4] == LOOP_GROUP) && (opcode[3:0] <= LAST_COND);
  assign lt       = flag_n ^ flag_v;

  always_comb begin
    case (opcode[3:0])
      4'h0:    cond_ok = lt;
      4'h1:    cond_ok = !(flag_z || lt);
      4'h2:    cond_ok = !lt;
      4'h3:    cond_ok = flag_z || lt;
      4'h4:    cond_ok = flag_c;
      4'h5:    cond_ok = !(flag_c || flag_z);
      4'h6:    cond_ok = !flag_c;
      4'h7:    cond_ok = flag_c || flag_z;
      4'h8:    cond_ok = flag_z;
      4'h9:    cond_ok = !flag_z;
      4'hA:    cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  assign claim    = is_setup || is_loop;
  assign redirect = is_loop && cond_ok;

  always_comb begin
    if (redirect)      next_pc = loop_addr - PC_W'(BACK_OFFSET);
    else if (is_loop)  next_pc = instr_addr + PC_W'(BRANCH_LEN);
    else if (is_setup) next_pc = instr_addr + PC_W'(SETUP_LEN);
    else               next_pc = instr_addr;
  end

  genvar gb;
  generate
    for (gb = 0; gb < 4; gb++) begin : g_swap
      assign packed_word[31-8*gb -: 8] = tail_bytes[8*gb +: 8];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_addr <= '0;
      loop_word <= '0;
    end else if (is_setup) begin
      loop_addr <= instr_addr + PC_W'(SETUP_LEN);
      loop_word <= packed_word;
    end
  end

  AST_SETUP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode == 8'hDB) |=> (loop_addr == $past(instr_addr) + PC_W'(5))); // R3
  AST_SETUP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode == 8'hDB) |=> (loop_word[31:24] == $past(tail_bytes[7:0]) && loop_word[7:0] == $past(tail_bytes[31:24]))); // R2
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && opcode == 8'hDB) |=> ($stable(loop_addr) && $stable(loop_word))); // R8
  AST_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (claim && next_pc + PC_W'(4) == loop_addr)); // R5
  AST_FALL_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !redirect && opcode != 8'hDB) |-> (next_pc == instr_addr + PC_W'(1))); // R6
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opcode == 8'hDA) |-> redirect); // R7
  AST_IDLE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |-> (!redirect && next_pc == instr_addr)); // R9

endmodule

// File: tb/loop_branch_unit_tb.sv
module loop_branch_unit_tb;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [PC_W-1:0] instr_addr = '0;
  logic [7:0]      opcode = 8'h00;
  logic [31:0]     tail_bytes = '0;
  logic [3:0]      flags = 4'h0;
  logic            claim, redirect;
  logic [PC_W-1:0] next_pc, loop_addr;
  logic [31:0]     loop_word;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  loop_branch_unit #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_addr(instr_addr),
    .opcode(opcode), .tail_bytes(tail_bytes),
    .flag_z(flags[3]), .flag_n(flags[2]), .flag_c(flags[1]), .flag_v(flags[0]),
    .claim(claim), .redirect(redirect), .next_pc(next_pc),
    .loop_addr(loop_addr), .loop_word(loop_word));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_take(input logic [3:0] code, input logic [3:0] f);
    bit z, n, c, v;
    z = f[3]; n = f[2]; c = f[1]; v = f[0];
    case (code)
      4'h0: return n != v;
      4'h1: return !z && (n == v);
      4'h2: return n == v;
      4'h3: return z || (n != v);
      4'h4: return c;
      4'h5: return !c && !z;
      4'h6: return !c;
      4'h7: return c || z;
      4'h8: return z;
      4'h9: return !z;
      default: return 1'b1;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [PC_W-1:0] a, input logic [7:0] op,
                       input logic [31:0] tb_bytes, input logic [3:0] f);
    @(negedge clk);
    instr_valid = v; instr_addr = a; opcode = op; tail_bytes = tb_bytes; flags = f;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] a;
    bit t;
    repeat (3) @(negedge clk);
    chk("R1 reset loop_addr", loop_addr, 0);
    chk("R1 reset loop_word", loop_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release loop_addr", loop_addr, 0);

    drive(1, 32'h100, 8'hDA, 0, 4'h0);
    chk("R10 pre-setup redirect", redirect, 1);
    chk("R10 pre-setup next_pc", next_pc, 64'hFFFF_FFFC);

    drive(1, 32'h1000, 8'hDB, 32'h4433_2211, 4'h0);
    chk("R3 setup claim", claim, 1);
    chk("R3 setup redirect", redirect, 0);
    chk("R3 setup next_pc", next_pc, 32'h1005);
    drive(0, 32'h0, 8'h00, 0, 4'h0);
    chk("R3 loop_addr", loop_addr, 32'h1005);
    chk("R2 loop_word big-endian", loop_word, 32'h1122_3344);

    for (int op = 8'hD0; op <= 8'hDA; op++) begin
      for (int f = 0; f < 16; f++) begin
        a = 32'h2000 + op * 16 + f;
        t = exp_take(op[3:0], f[3:0]);
        drive(1, a, op[7:0], 32'hDEAD_BEEF, f[3:0]);
        chk("R4 loop claim", claim, 1);
        chk("R4 condition map", redirect, t);
        if (op == 8'hDA) chk("R7 always taken", redirect, 1);
        if (t) chk("R5 taken next_pc", next_pc, 32'h1001);
        else   chk("R6 fallthrough next_pc", next_pc, a + 1);
      end
    end
    drive(0, 0, 8'h00, 0, 4'h0);
    chk("R8 loop_addr after branches", loop_addr, 32'h1005);
    chk("R8 loop_word after branches", loop_word, 32'h1122_3344);

    for (int op = 0; op < 256; op++) begin
      if (op >= 8'hD0 && op <= 8'hDB) continue;
      drive(1, 32'h3000 + op, op[7:0], 32'h5566_7788, 4'hF);
      chk("R9 unclaimed claim", claim, 0);
      chk("R9 unclaimed redirect", redirect, 0);
      chk("R9 unclaimed next_pc", next_pc, 32'h3000 + op);
    end
    drive(0, 32'h4000, 8'hDB, 32'h0102_0304, 4'h0);
    chk("R9 invalid setup claim", claim, 0);
    chk("R9 invalid setup next_pc", next_pc, 32'h4000);
    drive(0, 32'h4000, 8'hDA, 0, 4'h0);
    chk("R9 invalid branch redirect", redirect, 0);
    chk("R8 loop_addr after unclaimed", loop_addr, 32'h1005);
    chk("R8 loop_word after unclaimed", loop_word, 32'h1122_3344);

    drive(1, 32'hFFFF_FFFE, 8'hDB, 32'hA1B2_C3D4, 4'h0);
    chk("R3 wrap setup next_pc", next_pc, 32'h3);
    drive(1, 32'h80, 8'hD8, 0, 4'h8);
    chk("R3 wrap loop_addr", loop_addr, 32'h3);
    chk("R2 second loop_word", loop_word, 32'hD4C3_B2A1);
    chk("R5 taken after wrap", next_pc, 32'hFFFF_FFFF);
    drive(1, 32'h80, 8'hD8, 0, 4'h0);
    chk("R6 eq not taken", next_pc, 32'h81);

    rst_n = 1'b0;
    #1;
    chk("R1 re-reset loop_addr", loop_addr, 0);
    chk("R1 re-reset loop_word", loop_word, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule